// File: doc/BRIEF.md
# Ramp-Coded Neighbourhood Cell Array

This block is a grid of small digital cells that together apply one step of a piecewise-linear neighbourhood operator to an image kept inside the grid. Each cell stores a state word and an input word. A shared ramp sweeps upward. At every ramp step, each stored word becomes a single bit that is high while the word is above the ramp. A cell joins its own bit with the bits of its four nearest neighbours to form a 5-bit index. That index selects one bit from a programmable 32-entry table. The cell's counter adds up the selected bits over the whole sweep, and when the iteration ends the count becomes the new state word.

The host loads state and input words through a pixel write port and fills the two tables (one for the state pass, one for the input pass) through a table write port. It then pulses `start`. The grid is swept one column at a time. Each column receives a full state-pass sweep and, when enabled, a full input-pass sweep. Grayscale mode sweeps 64 ramp values. Binary mode uses a single step. A one-cycle `done` marks the moment the counts are copied into the state words. Afterwards the state words can be read back by row and column.

Top module: `scnn_array`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every state word reads back as 0.
- R2: While idle, a pixel write with `pix_sel`=0 loads the state word at (`pix_row`,`pix_col`) and with `pix_sel`=1 loads the input word. `rd_data` returns the state word at (`rd_row`,`rd_col`) combinationally.
- R3: While idle, `tbl_we` writes `tbl_wdata` into entry `tbl_addr` of the state-pass table (`tbl_sel`=0) or the input-pass table (`tbl_sel`=1).
- R4: The table index is bit0 = the cell's own bit, bit1 = the cell one row up, bit2 = one row down, bit3 = one column left, bit4 = one column right. A neighbour position outside the grid contributes 0.
- R5: In grayscale mode (`mode_bw`=0), ramp step k (k = 0..63) compares against the value 2k, and a word's bit is 1 when the word > 2k. The pass count is the number of steps whose selected table bit is 1. With an identity table, a state word of 100 becomes 50.
- R6: With `use_u`=1, a second pass uses the input words and the input-pass table. The counts of both passes add, and the total saturates at 127.
- R7: In binary mode (`mode_bw`=1), each pass has a single step, and a word's bit is 1 when the word is nonzero.
- R8: Columns are processed in ascending order. An iteration has COLS × passes × steps counting cycles, and `done` is high in the cycle after the last one. Seen from the falling edge after the `start` edge, `done` is observed on falling edge COLS×passes×steps+1.
- R9: `done` lasts exactly one cycle. At its end each state word takes its cell's count, `busy` drops, and the counters clear, so a second iteration starts counting from zero.
- R10: While `busy` is high, `start`, pixel writes and table writes have no effect. The running iteration keeps its length and its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one iteration when idle |
| mode_bw | input | 1 | 1 = binary single-step mode, 0 = grayscale 64-step mode |
| use_u | input | 1 | 1 = add the input-word pass |
| pix_we | input | 1 | Pixel write strobe |
| pix_sel | input | 1 | 0 = state word, 1 = input word |
| pix_row | input | RW | Write row |
| pix_col | input | CW | Write column |
| pix_wdata | input | W | Word to write |
| rd_row | input | RW | Readback row |
| rd_col | input | CW | Readback column |
| rd_data | output | W | State word at the readback position |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 = state-pass table, 1 = input-pass table |
| tbl_addr | input | 5 | Table entry index |
| tbl_wdata | input | 1 | Table entry value |
| busy | output | 1 | Iteration in progress (including the commit cycle) |
| done | output | 1 | One-cycle end-of-iteration pulse |

## Verification
The operator is tried with an identity table, which separates ramp scaling from neighbour wiring. A neighbourhood-OR table and an all-five-high table show that the edge cells read zero past the border. Tables that select only one neighbour bit pin down the order of the index bits. Mixed-mode runs with the input pass enabled show that the two passes use separate tables and that their counts add and saturate. Cycle counts in all four mode combinations, together with a run disturbed by writes and a repeated start, tell apart a sequencer that miscounts, one that restarts, and one that lets writes through while busy.

// File: rtl/scnn_pkg.sv
package scnn_pkg;
  localparam int CELL_W = 7;
  localparam int NBR_N  = 4;
  localparam int TBL_N  = 32;

  // nb = {right, left, down, up}; own bit lands in index bit 0
  function automatic logic [4:0] nbr_addr(input logic self_bit, input logic [NBR_N-1:0] nb);
    return {nb, self_bit};
  endfunction

  function automatic logic lut_pick(input logic [TBL_N-1:0] tbl, input logic [4:0] idx);
    return tbl[idx];
  endfunction
endpackage

// File: rtl/scnn_seq.sv
module scnn_seq #(
  parameter int COLS = 8,
  parameter int CW   = 3,
  parameter int SW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_bw,
  input  logic          use_u,
  output logic          busy,
  output logic          done,
  output logic          step_fire,
  output logic          commit,
  output logic [CW-1:0] act_col,
  output logic          pass_u,
  output logic [SW-1:0] step
);
  logic          run_q, commit_q, pass_q, bw_q, u_q;
  logic [CW-1:0] col_q;
  logic [SW-1:0] step_q;
  logic          last_step, last_pass, last_col, iter_end;

  assign last_step = (step_q == (bw_q ? '0 : {SW{1'b1}}));
  assign last_pass = (pass_q == u_q);
  assign last_col  = (col_q == CW'(COLS-1));
  assign iter_end  = last_step && last_pass && last_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; commit_q <= 1'b0; pass_q <= 1'b0;
      bw_q <= 1'b0; u_q <= 1'b0; col_q <= '0; step_q <= '0;
    end else begin
      commit_q <= run_q && iter_end;
      if (run_q) begin
        if (!last_step) step_q <= step_q + 1'b1;
        else begin
          step_q <= '0;
          if (!last_pass) pass_q <= 1'b1;
          else begin
            pass_q <= 1'b0;
            if (last_col) run_q <= 1'b0;
            else col_q <= col_q + 1'b1;
          end
        end
      end else if (!commit_q && start) begin
        run_q <= 1'b1; col_q <= '0; pass_q <= 1'b0; step_q <= '0;
        bw_q <= mode_bw; u_q <= use_u;
      end
    end
  end

  assign busy      = run_q | commit_q;
  assign done      = commit_q;
  assign commit    = commit_q;
  assign step_fire = run_q;
  assign act_col   = col_q;
  assign pass_u    = pass_q;
  assign step      = step_q;
endmodule

// File: rtl/scnn_cell.sv
module scnn_cell
  import scnn_pkg::*;
#(
  parameter int W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_x,
  input  logic              ld_u,
  input  logic [W-1:0]      wdata,
  input  logic              commit,
  input  logic              acc_en,
  input  logic [W-1:0]      ramp,
  input  logic              pass_u,
  input  logic [NBR_N-1:0]  nbr_f,
  input  logic [NBR_N-1:0]  nbr_g,
  input  logic [TBL_N-1:0]  tbl_x,
  input  logic [TBL_N-1:0]  tbl_u,
  output logic [W-1:0]      x_word,
  output logic              f_bit,
  output logic              g_bit,
  output logic              hit
);
  logic [W-1:0] x_q, u_q, cnt_q;
  logic [4:0]   idx;

  assign f_bit = (x_q > ramp);
  assign g_bit = (u_q > ramp);
  assign idx   = pass_u ? nbr_addr(g_bit, nbr_g) : nbr_addr(f_bit, nbr_f);
  assign hit   = pass_u ? lut_pick(tbl_u, idx) : lut_pick(tbl_x, idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0; u_q <= '0; cnt_q <= '0;
    end else begin
      if (commit) begin
        x_q   <= cnt_q;
        cnt_q <= '0;
      end else if (acc_en && hit && (cnt_q != {W{1'b1}})) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ld_x) x_q <= wdata;
      if (ld_u) u_q <= wdata;
    end
  end

  assign x_word = x_q;
endmodule

// File: rtl/scnn_array.sv
module scnn_array
  import scnn_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 8,
  parameter int W    = CELL_W,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int SW  = W - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_bw,
  input  logic          use_u,
  input  logic          pix_we,
  input  logic          pix_sel,
  input  logic [RW-1:0] pix_row,
  input  logic [CW-1:0] pix_col,
  input  logic [W-1:0]  pix_wdata,
  input  logic [RW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [W-1:0]  rd_data,
  input  logic          tbl_we,
  input  logic          tbl_sel,
  input  logic [4:0]    tbl_addr,
  input  logic          tbl_wdata,
  output logic          busy,
  output logic          done
);
  logic             step_fire, commit, pass_u;
  logic [CW-1:0]    act_col;
  logic [SW-1:0]    step;
  logic [W-1:0]     ramp;
  logic [TBL_N-1:0] tbl_x_q, tbl_u_q;
  logic             wr_open;

  logic [W-1:0] x_arr [ROWS][COLS];
  logic         f_arr [ROWS][COLS];
  logic         g_arr [ROWS][COLS];
  logic         hit_arr [ROWS][COLS];

  scnn_seq #(.COLS(COLS), .CW(CW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_bw(mode_bw), .use_u(use_u),
    .busy(busy), .done(done), .step_fire(step_fire), .commit(commit),
    .act_col(act_col), .pass_u(pass_u), .step(step)
  );

  assign ramp    = {step, 1'b0};
  assign wr_open = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_x_q <= '0;
      tbl_u_q <= '0;
    end else if (tbl_we && wr_open) begin
      if (tbl_sel) tbl_u_q[tbl_addr] <= tbl_wdata;
      else         tbl_x_q[tbl_addr] <= tbl_wdata;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int RU = (r > 0) ? r - 1 : 0;
      localparam int RD = (r < ROWS - 1) ? r + 1 : r;
      localparam int CL = (c > 0) ? c - 1 : 0;
      localparam int CR = (c < COLS - 1) ? c + 1 : c;
      logic [NBR_N-1:0] nf, ng;
      logic             here;

      assign nf[0] = (r > 0)        ? f_arr[RU][c] : 1'b0;
      assign nf[1] = (r < ROWS - 1) ? f_arr[RD][c] : 1'b0;
      assign nf[2] = (c > 0)        ? f_arr[r][CL] : 1'b0;
      assign nf[3] = (c < COLS - 1) ? f_arr[r][CR] : 1'b0;
      assign ng[0] = (r > 0)        ? g_arr[RU][c] : 1'b0;
      assign ng[1] = (r < ROWS - 1) ? g_arr[RD][c] : 1'b0;
      assign ng[2] = (c > 0)        ? g_arr[r][CL] : 1'b0;
      assign ng[3] = (c < COLS - 1) ? g_arr[r][CR] : 1'b0;
      assign here  = pix_we && wr_open && (pix_row == RW'(r)) && (pix_col == CW'(c));

      scnn_cell #(.W(W)) u_cell (
        .clk(clk), .rst_n(rst_n),
        .ld_x(here && !pix_sel), .ld_u(here && pix_sel), .wdata(pix_wdata),
        .commit(commit), .acc_en(step_fire && (act_col == CW'(c))),
        .ramp(ramp), .pass_u(pass_u), .nbr_f(nf), .nbr_g(ng),
        .tbl_x(tbl_x_q), .tbl_u(tbl_u_q),
        .x_word(x_arr[r][c]), .f_bit(f_arr[r][c]), .g_bit(g_arr[r][c]),
        .hit(hit_arr[r][c])
      );
    end
  end

  assign rd_data = x_arr[rd_row][rd_col];
endmodule

// File: rtl/scnn_chk.sv
module scnn_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          step_fire,
  input logic [CW-1:0] act_col
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R9
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R10
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && step_fire)); // R8
  AST_COL_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> (!step_fire || act_col == $past(act_col) || act_col == $past(act_col) + 1'b1)); // R8
  AST_DONE_AFTER_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(step_fire)); // R8
endmodule

bind scnn_array scnn_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .step_fire(step_fire), .act_col(act_col)
);

// File: tb/sim_scnn_array.sv
module sim_scnn_array;
  localparam int ROWS = 6;
  localparam int COLS = 8;
  localparam int W    = 7;
  localparam int RW   = 3;
  localparam int CW   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, mode_bw = 0, use_u = 0, pix_we = 0, pix_sel = 0;
  logic [RW-1:0] pix_row = '0, rd_row = '0;
  logic [CW-1:0] pix_col = '0, rd_col = '0;
  logic [W-1:0]  pix_wdata = '0, rd_data;
  logic tbl_we = 0, tbl_sel = 0, tbl_wdata = 0;
  logic [4:0] tbl_addr = '0;
  logic busy, done;

  int n_chk = 0, n_bad = 0;
  int mx [ROWS][COLS];
  int mu [ROWS][COLS];
  logic [31:0] mtx, mtu;

  always #4 clk = ~clk;

  scnn_array #(.ROWS(ROWS), .COLS(COLS), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_bw(mode_bw), .use_u(use_u),
    .pix_we(pix_we), .pix_sel(pix_sel), .pix_row(pix_row), .pix_col(pix_col),
    .pix_wdata(pix_wdata), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .busy(busy), .done(done)
  );

  // fields: bw, use_u, state table, input table, seed
  localparam logic [72:0] VEC [5] = '{
    {1'b0, 1'b0, 32'hAAAAAAAA, 32'h00000000, 7'd1},
    {1'b0, 1'b0, 32'hFFFFFFFE, 32'h00000000, 7'd2},
    {1'b0, 1'b1, 32'h80000000, 32'hAAAAAAAA, 7'd3},
    {1'b1, 1'b0, 32'h80000000, 32'h00000000, 7'd4},
    {1'b1, 1'b1, 32'hAAAAAAAA, 32'hFFFF0000, 7'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put_pix(input bit sel, input int r, input int c, input int v);
    @(negedge clk);
    pix_we = 1; pix_sel = sel; pix_row = RW'(r); pix_col = CW'(c); pix_wdata = W'(v);
    @(negedge clk);
    pix_we = 0;
    if (sel) mu[r][c] = v; else mx[r][c] = v;
  endtask

  task automatic put_tbl(input bit sel, input logic [31:0] t);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_sel = sel; tbl_addr = 5'(i); tbl_wdata = t[i];
    end
    @(negedge clk);
    tbl_we = 0;
    if (sel) mtu = t; else mtx = t;
  endtask

  task automatic get_x(input int r, input int c, output int v);
    rd_row = RW'(r); rd_col = CW'(c);
    #1;
    v = int'(rd_data);
  endtask

  function automatic int wbit(input bit sel, input int r, input int c, input int ramp);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0;
    return ((sel ? mu[r][c] : mx[r][c]) > ramp) ? 1 : 0;
  endfunction

  // independent model of one iteration on mx/mu
  task automatic model_iter(input bit bw, input bit uu);
    int nx [ROWS][COLS];
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        int cnt = 0;
        for (int p = 0; p < (uu ? 2 : 1); p++)
          for (int k = 0; k < (bw ? 1 : 64); k++) begin
            int a;
            a = wbit(p[0], r, c, 2*k) + 2*wbit(p[0], r-1, c, 2*k) + 4*wbit(p[0], r+1, c, 2*k)
              + 8*wbit(p[0], r, c-1, 2*k) + 16*wbit(p[0], r, c+1, 2*k);
            cnt += p ? int'(mtu[a]) : int'(mtx[a]);
          end
        nx[r][c] = (cnt > 127) ? 127 : cnt;
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mx[r][c] = nx[r][c];
  endtask

  // returns falling edges from the start edge to the observed done; disturb pokes writes and start mid-run
  task automatic run_iter(input bit bw, input bit uu, input bit disturb, output int cyc);
    @(negedge clk);
    start = 1; mode_bw = bw; use_u = uu;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 5000) begin
      if (disturb && cyc == 5) begin
        start = 1; pix_we = 1; pix_sel = 0; pix_row = '0; pix_col = '0; pix_wdata = 7'd99;
        tbl_we = 1; tbl_sel = 0; tbl_addr = 5'd1; tbl_wdata = ~mtx[1];
      end else begin
        start = 0; pix_we = 0; tbl_we = 0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; pix_we = 0; tbl_we = 0;
    @(negedge clk);
    chk(!done && !busy, "R9 done single cycle, busy released", int'(done), 0);
  endtask

  task automatic cmp_all(input string req);
    int v;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        get_x(r, c, v);
        chk(v == mx[r][c], req, v, mx[r][c]);
      end
  endtask

  task automatic fill(input int seed);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        put_pix(0, r, c, ((r*3 + c*5 + seed) % 4 == 0) ? 0 : (r*37 + c*11 + seed*53) % 128);
        put_pix(1, r, c, (r*13 + c*29 + seed*7) % 128);
      end
  endtask

  task automatic fill_const(input int v);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) put_pix(0, r, c, v);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, cyc;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin mx[r][c] = 0; mu[r][c] = 0; end
    mtx = '0; mtu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(!busy && !done, "R1 idle after reset", int'(busy), 0);
    get_x(0, 0, v); chk(v == 0, "R1 state word zero", v, 0);
    get_x(5, 7, v); chk(v == 0, "R1 state word zero", v, 0);

    // R2 load and readback
    put_pix(0, 2, 5, 77);
    get_x(2, 5, v); chk(v == 77, "R2 readback", v, 77);
    put_pix(1, 2, 5, 12);
    get_x(2, 5, v); chk(v == 77, "R2 input write leaves state", v, 77);

    // vector walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 5; i++) begin
      logic [72:0] vv;
      vv = VEC[i];
      fill(int'(vv[6:0]));
      put_tbl(0, vv[70:39]);
      put_tbl(1, vv[38:7]);
      run_iter(vv[72], vv[71], 0, cyc);
      chk(cyc == COLS * (vv[71] ? 2 : 1) * (vv[72] ? 1 : 64) + 1, "R8 iteration length",
          cyc, COLS * (vv[71] ? 2 : 1) * (vv[72] ? 1 : 64) + 1);
      model_iter(vv[72], vv[71]);
      cmp_all("R3 R4 R5 R6 R7 vector result");
    end

    // R5 identity scaling and R9 counter clear on a second run
    put_tbl(0, 32'hAAAAAAAA);
    put_pix(0, 1, 1, 100);
    run_iter(0, 0, 0, cyc);
    chk(cyc == 513, "R8 gray single pass length", cyc, 513);
    get_x(1, 1, v); chk(v == 50, "R5 identity 100 -> 50", v, 50);
    model_iter(0, 0);
    run_iter(0, 0, 0, cyc);
    get_x(1, 1, v); chk(v == 25, "R9 counters cleared between runs", v, 25);
    model_iter(0, 0);

    // R6 saturation
    put_tbl(1, 32'hAAAAAAAA);
    put_pix(0, 3, 3, 127);
    put_pix(1, 3, 3, 127);
    run_iter(0, 1, 0, cyc);
    chk(cyc == 1025, "R8 gray two-pass length", cyc, 1025);
    get_x(3, 3, v); chk(v == 127, "R6 saturate at 127", v, 127);
    model_iter(0, 1);

    // R7 binary mode nonzero test
    put_pix(0, 4, 2, 5);
    run_iter(1, 0, 0, cyc);
    get_x(4, 2, v); chk(v == 1, "R7 binary nonzero -> 1", v, 1);

    // R4 index order: only the up-neighbour entry set
    fill_const(0);
    put_pix(0, 2, 3, 1);
    put_tbl(0, 32'h00000004);
    run_iter(1, 0, 0, cyc);
    get_x(3, 3, v); chk(v == 1, "R4 up neighbour is bit1", v, 1);
    get_x(1, 3, v); chk(v == 0, "R4 down neighbour not bit1", v, 0);
    get_x(2, 3, v); chk(v == 0, "R4 own bit alone gives 0", v, 0);
    model_iter(1, 0);
    cmp_all("R4 index order grid");

    // R4 edges read 0: all-five table on a full image
    fill_const(1);
    put_tbl(0, 32'h80000000);
    run_iter(1, 0, 0, cyc);
    get_x(0, 0, v); chk(v == 0, "R4 corner sees zero border", v, 0);
    get_x(0, 3, v); chk(v == 0, "R4 top edge sees zero border", v, 0);
    get_x(2, 3, v); chk(v == 1, "R4 interior all ones", v, 1);

    // R10 writes and start ignored while busy
    fill(9);
    put_tbl(0, 32'hAAAAAAAA);
    run_iter(0, 0, 1, cyc);
    chk(cyc == 513, "R10 restart ignored, length kept", cyc, 513);
    model_iter(0, 0);
    cmp_all("R10 busy writes ignored");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule